// File: doc/BRIEF.md
# Cross-Point Resistive Array Bias Sequencer

This block drives a bank of small cross-point resistive memory arrays. A request names a row, a column and, for writes, a data word. The block turns the request into a two-bit bias code for every wordline and every bitline of every array. It then steps through a short fixed sequence and returns all lines to ground. The analog line drivers and the sense amplifiers sit outside the block: it sees them only as codes out and digital sense bits in.

A data word is spread across the arrays. Word bit i lives in array i, at the same row and column in every array. A write therefore programs exactly one cell in each array, and all the bits of the word are programmed in parallel. The polarity of each array's drive follows that array's data bit.

A read raises only the addressed wordline, in every array, and grounds every other line. The external sense amplifiers return one bit per bitline. For each array, the block keeps the bit of the addressed column and assembles these bits into the result word.

Top module: `xpt_bias_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `busy` and `rd_valid` are 0 and every wordline and bitline code is 00.
- R2: Line codes are two bits wide: 00 is ground, 01 is half (also used as the sub-threshold read level), 10 is full positive drive (programs a 1), and 11 is full negative drive (programs a 0). Line k of array a occupies bits [2*(a*8+k)+1 : 2*(a*8+k)] of its bus.
- R3: During the drive cycles of a write, in each array a, the addressed wordline and the addressed bitline carry 10 if data bit a is 1, and 11 if it is 0.
- R4: During the drive cycles of a write, every other wordline and bitline of every array carries 01.
- R5: A write accepted at a clock edge keeps `busy` high for three cycles. The first two cycles drive the write bias, and in the third every code is 00. `busy` falls after that third cycle.
- R6: During a read, the addressed wordline of every array carries 01, and every other wordline and every bitline carries 00.
- R7: A read keeps `busy` high for two cycles, both of them driving the read bias. In the cycle after those two, `busy` is 0 and `rd_valid` is 1 for exactly one cycle.
- R8: The sense bus bit a*8+c is the bitline c of array a. `rd_data[a]` takes the sense bit of the addressed column of array a, sampled at the end of the second read cycle, and holds its value until the next read completes.
- R9: A request is accepted only when `busy` is 0. A request made while `busy` is 1 changes neither the codes nor the later read results.
- R10: Bit i of the data word is written into array i at the addressed row and column, so each write programs exactly one cell per array.
- R11: Whenever `busy` is 0, every wordline and bitline code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_row | input | 3 | Addressed wordline |
| req_col | input | 3 | Addressed bitline |
| req_data | input | 8 | Write word; bit i goes to array i |
| busy | output | 1 | High while an operation is in progress |
| rd_valid | output | 1 | One-cycle pulse when the read result is valid |
| rd_data | output | 8 | Read word; bit i comes from array i |
| wl_bias | output | 128 | Two-bit code for each wordline of each array |
| bl_bias | output | 128 | Two-bit code for each bitline of each array |
| sense | input | 64 | Sensed bitline states, one bit per bitline per array |

## Verification
The assertions take for granted that the request inputs carry meaningful values only while `req_valid` is high. They also assume the `sense` bus is stable around the edge that ends a read. The bench drives every input on the falling clock edge and holds `sense` at the bench's model of the addressed row throughout the read. It drops `req_valid` before `busy` falls, so a request made during an operation cannot slip in when the block returns to idle. The addresses are swept across all 64 row and column pairs, with data that varies per address, so that a wrong column pick or a wrong array mapping changes the word that is read back.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  typedef enum logic [1:0] {
    BIAS_GND  = 2'b00,
    BIAS_HALF = 2'b01,
    BIAS_POS  = 2'b10,
    BIAS_NEG  = 2'b11
  } bias_e;

  typedef enum logic [1:0] {
    DRV_OFF   = 2'b00,
    DRV_WRITE = 2'b01,
    DRV_READ  = 2'b10
  } drive_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAPP  = 3'd1,
    ST_WHOLD = 3'd2,
    ST_WGND  = 3'd3,
    ST_RAPP  = 3'd4,
    ST_RSAMP = 3'd5
  } state_e;
endpackage

// File: rtl/xpt_seq.sv
module xpt_seq
  import xpt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output logic   busy,
  output logic   accept,
  output logic   sample,
  output drive_e drive
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = req_write ? ST_WAPP : ST_RAPP;
      ST_WAPP:  state_d = ST_WHOLD;
      ST_WHOLD: state_d = ST_WGND;
      ST_WGND:  state_d = ST_IDLE;
      ST_RAPP:  state_d = ST_RSAMP;
      ST_RSAMP: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    busy   = (state_q != ST_IDLE);
    accept = req_valid && (state_q == ST_IDLE);
    sample = (state_q == ST_RSAMP);
    case (state_q)
      ST_WAPP, ST_WHOLD: drive = DRV_WRITE;
      ST_RAPP, ST_RSAMP: drive = DRV_READ;
      default:           drive = DRV_OFF;
    endcase
  end
endmodule

// File: rtl/xpt_line_bias.sv
module xpt_line_bias
  import xpt_pkg::*;
#(
  parameter int N_ROW = 8,
  parameter int N_COL = 8,
  localparam int RW = $clog2(N_ROW),
  localparam int CW = $clog2(N_COL)
) (
  input  drive_e              drive,
  input  logic [RW-1:0]       row,
  input  logic [CW-1:0]       col,
  input  logic                wbit,
  output logic [2*N_ROW-1:0]  wl,
  output logic [2*N_COL-1:0]  bl
);
  bias_e full_code;
  assign full_code = wbit ? BIAS_POS : BIAS_NEG;

  for (genvar k = 0; k < N_ROW; k++) begin : g_wl
    localparam logic [RW-1:0] KR = RW'(k);
    always_comb begin
      case (drive)
        DRV_WRITE: wl[2*k+:2] = (row == KR) ? full_code : BIAS_HALF;
        DRV_READ:  wl[2*k+:2] = (row == KR) ? BIAS_HALF : BIAS_GND;
        default:   wl[2*k+:2] = BIAS_GND;
      endcase
    end
  end

  for (genvar k = 0; k < N_COL; k++) begin : g_bl
    localparam logic [CW-1:0] KC = CW'(k);
    always_comb begin
      case (drive)
        DRV_WRITE: bl[2*k+:2] = (col == KC) ? full_code : BIAS_HALF;
        default:   bl[2*k+:2] = BIAS_GND;
      endcase
    end
  end
endmodule

// File: rtl/xpt_sense_pick.sv
module xpt_sense_pick #(
  parameter int N_ARR = 8,
  parameter int N_COL = 8,
  localparam int CW = $clog2(N_COL)
) (
  input  logic [N_ARR*N_COL-1:0] sense,
  input  logic [CW-1:0]          col,
  output logic [N_ARR-1:0]       bits
);
  for (genvar a = 0; a < N_ARR; a++) begin : g_pick
    logic [N_COL-1:0] slice;
    assign slice   = sense[a*N_COL +: N_COL];
    assign bits[a] = slice[col];
  end
endmodule

// File: rtl/xpt_bias_ctrl.sv
module xpt_bias_ctrl
  import xpt_pkg::*;
#(
  parameter int N_ARR = 8,
  parameter int N_ROW = 8,
  parameter int N_COL = 8,
  localparam int RW = $clog2(N_ROW),
  localparam int CW = $clog2(N_COL)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [RW-1:0]            req_row,
  input  logic [CW-1:0]            req_col,
  input  logic [N_ARR-1:0]         req_data,
  output logic                     busy,
  output logic                     rd_valid,
  output logic [N_ARR-1:0]         rd_data,
  output logic [2*N_ARR*N_ROW-1:0] wl_bias,
  output logic [2*N_ARR*N_COL-1:0] bl_bias,
  input  logic [N_ARR*N_COL-1:0]   sense
);
  logic             accept, sample;
  drive_e           drive;
  logic [RW-1:0]    row_q;
  logic [CW-1:0]    col_q;
  logic [N_ARR-1:0] data_q, rd_data_q, picked;
  logic             rd_valid_q;

  xpt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .busy(busy), .accept(accept), .sample(sample), .drive(drive)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      row_q  <= req_row;
      col_q  <= req_col;
      data_q <= req_data;
    end
  end

  for (genvar a = 0; a < N_ARR; a++) begin : g_arr
    xpt_line_bias #(.N_ROW(N_ROW), .N_COL(N_COL)) u_lb (
      .drive(drive), .row(row_q), .col(col_q), .wbit(data_q[a]),
      .wl(wl_bias[2*N_ROW*a +: 2*N_ROW]),
      .bl(bl_bias[2*N_COL*a +: 2*N_COL])
    );
  end

  xpt_sense_pick #(.N_ARR(N_ARR), .N_COL(N_COL)) u_pick (
    .sense(sense), .col(col_q), .bits(picked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= sample;
      if (sample) rd_data_q <= picked;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/xpt_bias_chk.sv
module xpt_bias_chk #(
  parameter int N_ARR = 8,
  parameter int N_ROW = 8,
  parameter int N_COL = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_write,
  input logic                     busy,
  input logic                     rd_valid,
  input logic [2*N_ARR*N_ROW-1:0] wl_bias,
  input logic [2*N_ARR*N_COL-1:0] bl_bias
);
  function automatic int n_full_wl(input logic [2*N_ARR*N_ROW-1:0] v);
    int n = 0;
    for (int i = 0; i < N_ARR*N_ROW; i++) n += int'(v[2*i+1]);
    return n;
  endfunction

  function automatic int n_full_bl(input logic [2*N_ARR*N_COL-1:0] v);
    int n = 0;
    for (int i = 0; i < N_ARR*N_COL; i++) n += int'(v[2*i+1]);
    return n;
  endfunction

  // R11
  idle_ground_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wl_bias == '0 && bl_bias == '0));

  // R10
  one_cell_per_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_full_wl(wl_bias) == 0 || n_full_wl(wl_bias) == N_ARR) &&
    n_full_wl(wl_bias) == n_full_bl(bl_bias));

  // R5
  write_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(req_write)) |-> ##2 busy ##1 !busy);

  // R7
  read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(req_write)) |-> ##1 busy ##1 (!busy && rd_valid));

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $past(busy)) ##1 !rd_valid);

  // R9
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

bind xpt_bias_ctrl xpt_bias_chk #(.N_ARR(N_ARR), .N_ROW(N_ROW), .N_COL(N_COL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .busy(busy), .rd_valid(rd_valid), .wl_bias(wl_bias), .bl_bias(bl_bias)
);

// File: tb/xpt_bias_ctrl_tb.sv
module xpt_bias_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8, NR = 8, NC = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid, req_write;
  logic [2:0]      req_row, req_col;
  logic [NA-1:0]   req_data;
  logic            busy, rd_valid;
  logic [NA-1:0]   rd_data;
  logic [127:0]    wl_bias, bl_bias;
  logic [NA*NC-1:0] sense;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [NA-1:0] model [NR*NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_bias_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_data(req_data),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .wl_bias(wl_bias), .bl_bias(bl_bias), .sense(sense)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // mode: 0 idle, 1 write, 2 read
  function automatic logic [127:0] exp_wl(int mode, int r, logic [NA-1:0] d);
    logic [127:0] v = '0;
    for (int a = 0; a < NA; a++)
      for (int k = 0; k < NR; k++) begin
        logic [1:0] code = 2'b00;
        if (mode == 1) code = (k == r) ? (d[a] ? 2'b10 : 2'b11) : 2'b01;
        if (mode == 2) code = (k == r) ? 2'b01 : 2'b00;
        v[2*(a*NR+k) +: 2] = code;
      end
    return v;
  endfunction

  function automatic logic [127:0] exp_bl(int mode, int c, logic [NA-1:0] d);
    logic [127:0] v = '0;
    for (int a = 0; a < NA; a++)
      for (int k = 0; k < NC; k++)
        if (mode == 1) v[2*(a*NC+k) +: 2] = (k == c) ? (d[a] ? 2'b10 : 2'b11) : 2'b01;
    return v;
  endfunction

  function automatic logic [NA*NC-1:0] row_image(int r);
    logic [NA*NC-1:0] s = '0;
    for (int a = 0; a < NA; a++)
      for (int c = 0; c < NC; c++) s[a*NC+c] = model[r*NC+c][a];
    return s;
  endfunction

  task automatic do_write(int r, int c, logic [NA-1:0] d, bit poke);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_row = 3'(r); req_col = 3'(c); req_data = d;
    @(negedge clk);
    req_valid = 0;
    chk("R5 busy w1", 128'(busy), 128'(1));
    chk("R3 R4 R10 wl", wl_bias, exp_wl(1, r, d));
    chk("R3 R4 R10 bl", bl_bias, exp_bl(1, c, d));
    if (poke) begin
      req_valid = 1; req_write = 1; req_row = 3'(r+1); req_col = 3'(c+3); req_data = ~d;
    end
    @(negedge clk);
    chk("R5 busy w2", 128'(busy), 128'(1));
    chk("R9 R5 wl hold", wl_bias, exp_wl(1, r, d));
    chk("R9 R5 bl hold", bl_bias, exp_bl(1, c, d));
    req_valid = 0;
    @(negedge clk);
    chk("R5 busy w3", 128'(busy), 128'(1));
    chk("R5 ground", wl_bias | bl_bias, 128'(0));
    @(negedge clk);
    chk("R5 busy end", 128'(busy), 128'(0));
    chk("R11 idle ground", wl_bias | bl_bias, 128'(0));
    model[r*NC+c] = d;
  endtask

  task automatic do_read(int r, int c);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_row = 3'(r); req_col = 3'(c); req_data = $urandom;
    @(negedge clk);
    req_valid = 0;
    sense = row_image(r);
    chk("R7 busy r1", 128'(busy), 128'(1));
    chk("R6 wl", wl_bias, exp_wl(2, r, '0));
    chk("R6 bl", bl_bias, 128'(0));
    @(negedge clk);
    chk("R7 busy r2", 128'(busy), 128'(1));
    chk("R6 wl hold", wl_bias, exp_wl(2, r, '0));
    @(negedge clk);
    sense = ~sense;
    chk("R7 done", {busy, rd_valid}, 128'(2'b01));
    chk("R8 R10 data", 128'(rd_data), 128'(model[r*NC+c]));
    @(negedge clk);
    chk("R7 pulse", 128'(rd_valid), 128'(0));
    chk("R8 hold", 128'(rd_data), 128'(model[r*NC+c]));
  endtask

  initial begin
    for (int i = 0; i < NR*NC; i++) model[i] = '0;
    rst_n = 0; req_valid = 0; req_write = 0; req_row = '0; req_col = '0;
    req_data = '0; sense = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {busy, rd_valid}, 128'(0));
    chk("R1 reset bias", wl_bias | bl_bias, 128'(0));
    rst_n = 1;
    @(negedge clk);
    chk("R1 R2 after release", wl_bias | bl_bias, 128'(0));
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        do_write(r, c, 8'((r*NC+c)*37 + 5) ^ 8'(r << 4), (r + c) % 5 == 0);
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) do_read(r, c);
    for (int r = 0; r < NR; r++) begin
      do_write(r, NC-1-r, ~model[r*NC+NC-1-r], 1);
      do_read(r, NC-1-r);
      do_write(r, r, 8'hFF, 0);
      do_read(r, r);
      do_write(r, r, 8'h00, 0);
      do_read(r, r);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule